// File: doc/BRIEF.md
# Master configuration clock controller with error detection

This block is the control logic of the head device in a chain of serial configuration memories. A shared output-enable line acts as both reset and status. When that line is released, the block samples its chip-select input to choose its role. If chip select is low, it becomes the clock master. It then divides the system clock into a configuration clock and counts every rising edge, each edge being one data bit handed to the target. If chip select is high, it takes the follower role and never drives a clock.

As master, the block keeps clocking until the whole chain has delivered `TOTAL_BITS` bits. During the run, its chip-select input carries the target's done flag. If done arrives while bits remain, the block reports an error. If done never arrives within `DONE_TIMEOUT` clocks after the last bit, it also reports an error. If done arrives in time, the block issues `TAIL_CLKS` (16) more clock cycles for target start-up and then parks with the clock held low.

An error is reported by pulling the shared output-enable line low, which also stops the clock. With `AUTO_RESTART` set, the block holds the line low for `ERR_PULSE` system clocks, then releases it and starts over from bit zero. Otherwise, it stays in error until `rst_ni`.

Top module: `cfg_clk_master`

## Requirements
- R1: On the cycle `oe_i` is high after being low or after `rst_ni`, the block takes its role from `cs_ni`. Low makes it master (`master_o`=1), and the clock runs. High makes it a follower (`master_o`=0), and `dclk_o` stays low.
- R2: While running, `dclk_o` is low for `DIV_HALF` system clocks before its first rising edge, and each later high and low phase lasts `DIV_HALF` system clocks.
- R3: The bit count starts at zero on every start. `sent_all_o` goes high on the `TOTAL_BITS`-th rising edge of `dclk_o` and not before.
- R4: If `cs_ni` goes high after all bits are sent and within the timeout, exactly `TAIL_CLKS` (16) further rising edges of `dclk_o` follow. `idle_o` then goes high, and `dclk_o` stays low.
- R5: If `cs_ni` goes high while bits remain, `oe_pull_o` goes high and `dclk_o` stops low.
- R6: If `cs_ni` stays low after all bits are sent, `oe_pull_o` goes high on the `DONE_TIMEOUT`-th rising edge after the last data bit.
- R7: An external low on `oe_i` outside the error state stops `dclk_o` low, clears the bit count and returns the block to reset. The next start counts from zero.
- R8: With `AUTO_RESTART`=0, the error state and `oe_pull_o` persist, whatever `oe_i` and `cs_ni` do, until `rst_ni` is asserted.
- R9: With `AUTO_RESTART`=1, `oe_pull_o` is high for exactly `ERR_PULSE` system clocks. Configuration then restarts from bit zero.
- R10: While `rst_ni` is low, `dclk_o`, `oe_pull_o`, `master_o`, `sent_all_o` and `idle_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Level of the shared output-enable/status line; low means reset |
| cs_ni | input | 1 | Chip select at reset; the target's done flag during configuration |
| dclk_o | output | 1 | Generated configuration clock |
| oe_pull_o | output | 1 | High to pull the shared line low (error) |
| master_o | output | 1 | Block holds the clock-master role |
| sent_all_o | output | 1 | All `TOTAL_BITS` bits have been clocked out |
| idle_o | output | 1 | Configuration finished, block parked |

## Verification
The bench counts configuration clock edges and compares the counts with arithmetic from the parameters.

- **Done timing:** done is raised exactly at the end of the stream, a few edges late, early, and never. A design that mis-counted would show an off-by-one in the 16-edge tail or in the timeout edge, or would accept an early done as success.
- **Mid-stream reset:** the line is dropped mid-stream. A design that failed to clear its count would report completion too early after the restart.
- **Error latching and release:** error latching is checked against a toggling line. The auto-restart pulse width and the fresh count after release are measured on a second instance.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [2:0] {
    S_HOLD, S_SLAVE, S_RUN, S_WAIT, S_TAIL, S_IDLE, S_ERR
  } cfgm_state_e;
endpackage

// File: rtl/cfgm_clkgen.sv
module cfgm_clkgen #(
  parameter int DIV_HALF = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic dclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] div_q;
  logic          dclk_q;
  logic          tick;

  assign tick   = run_i && (div_q == DIV_LAST);
  assign rise_o = tick && !dclk_q;
  assign fall_o = tick && dclk_q;
  assign dclk_o = dclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      dclk_q <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      dclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      dclk_q <= !dclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  a_r2_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !dclk_o);
endmodule

// File: rtl/cfgm_ctrl.sv
module cfgm_ctrl
  import cfgm_pkg::*;
#(
  parameter int TOTAL_BITS   = 1024,
  parameter int DONE_TIMEOUT = 64,
  parameter int TAIL_CLKS    = 16,
  parameter int ERR_PULSE    = 32,
  parameter bit AUTO_RESTART = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  input  logic cs_ni,
  input  logic rise_i,
  input  logic fall_i,
  output logic run_o,
  output logic oe_pull_o,
  output logic master_o,
  output logic sent_all_o,
  output logic idle_o
);
  localparam int BW = $clog2(TOTAL_BITS + 1);
  localparam int WW = $clog2(DONE_TIMEOUT + 1);
  localparam int TW = $clog2(TAIL_CLKS + 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(TOTAL_BITS - 1);
  localparam logic [BW-1:0] BIT_ALL   = BW'(TOTAL_BITS);
  localparam logic [WW-1:0] WAIT_LAST = WW'(DONE_TIMEOUT - 1);
  localparam logic [TW-1:0] TAIL_ALL  = TW'(TAIL_CLKS);

  cfgm_state_e   state_q;
  logic          master_q;
  logic [BW-1:0] bit_q;
  logic [WW-1:0] wait_q;
  logic [TW-1:0] tail_q;
  logic          in_err;
  logic          err_release;

  assign in_err = (state_q == S_ERR);

  // error pulse timer only exists when restart is enabled
  if (AUTO_RESTART) begin : g_auto
    localparam int EW = $clog2(ERR_PULSE + 1);
    localparam logic [EW-1:0] ERR_LAST = EW'(ERR_PULSE - 1);
    logic [EW-1:0] err_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     err_q <= '0;
      else if (in_err) err_q <= err_q + 1'b1;
      else             err_q <= '0;
    end
    assign err_release = in_err && (err_q == ERR_LAST);
  end else begin : g_hold
    assign err_release = 1'b0;
    a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == S_ERR) |=> (state_q == S_ERR));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_HOLD;
      master_q <= 1'b0;
      bit_q    <= '0;
      wait_q   <= '0;
      tail_q   <= '0;
    end else if (!in_err && !oe_i) begin
      state_q  <= S_HOLD;
      master_q <= !cs_ni;
      bit_q    <= '0;
      wait_q   <= '0;
      tail_q   <= '0;
    end else begin
      unique case (state_q)
        S_HOLD: begin
          master_q <= !cs_ni;
          state_q  <= cs_ni ? S_SLAVE : S_RUN;
        end
        S_RUN: begin
          if (cs_ni) state_q <= S_ERR;       // done before end of stream
          else if (rise_i) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_LAST) state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cs_ni) begin
            state_q <= S_TAIL;
            tail_q  <= '0;
          end else if (rise_i) begin
            wait_q <= wait_q + 1'b1;
            if (wait_q == WAIT_LAST) state_q <= S_ERR;
          end
        end
        S_TAIL: begin
          if (rise_i) tail_q <= tail_q + 1'b1;
          else if (fall_i && tail_q == TAIL_ALL) state_q <= S_IDLE;
        end
        S_ERR: begin
          if (err_release) begin
            state_q <= S_HOLD;
            bit_q   <= '0;
            wait_q  <= '0;
            tail_q  <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign run_o      = (state_q == S_RUN) || (state_q == S_WAIT) || (state_q == S_TAIL);
  assign oe_pull_o  = in_err;
  assign master_o   = master_q;
  assign sent_all_o = (bit_q == BIT_ALL);
  assign idle_o     = (state_q == S_IDLE);

  a_r7_oe_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i && state_q != S_ERR) |=> (state_q == S_HOLD));
  a_r5_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && cs_ni && oe_i) |=> (state_q == S_ERR));
  a_r3_bits_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_ALL);
  a_r4_tail_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == S_IDLE) |-> (tail_q == TAIL_ALL));
endmodule

// File: rtl/cfg_clk_master.sv
module cfg_clk_master #(
  parameter int DIV_HALF     = 10,
  parameter int TOTAL_BITS   = 1046496,
  parameter int DONE_TIMEOUT = 64,
  parameter int TAIL_CLKS    = 16,
  parameter int ERR_PULSE    = 32,
  parameter bit AUTO_RESTART = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_i,
  input  logic cs_ni,
  output logic dclk_o,
  output logic oe_pull_o,
  output logic master_o,
  output logic sent_all_o,
  output logic idle_o
);
  logic run, rise, fall;

  cfgm_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk_i, .rst_ni, .run_i(run), .dclk_o, .rise_o(rise), .fall_o(fall)
  );

  cfgm_ctrl #(
    .TOTAL_BITS(TOTAL_BITS), .DONE_TIMEOUT(DONE_TIMEOUT), .TAIL_CLKS(TAIL_CLKS),
    .ERR_PULSE(ERR_PULSE), .AUTO_RESTART(AUTO_RESTART)
  ) u_ctrl (
    .clk_i, .rst_ni, .oe_i, .cs_ni, .rise_i(rise), .fall_i(fall),
    .run_o(run), .oe_pull_o, .master_o, .sent_all_o, .idle_o
  );

  a_r5_pull_stops_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_pull_o) |=> ##1 !dclk_o);
  a_r1_follower_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_o && $past(!master_o)) |-> !dclk_o);
endmodule

// File: tb/cfg_clk_master_bench.sv
`timescale 1ns/1ps
module cfg_clk_master_bench;
  localparam int DIVH = 2, NBITS = 20, TMO = 8, TAIL = 16, EPUL = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oe_ext = 1'b0, cs_n = 1'b0, oe_ext2 = 1'b0, cs_n2 = 1'b0;
  logic dclk, pull, master, sent, idle;
  logic dclk2, pull2, master2, sent2, idle2;
  logic oe_line, oe_line2;
  int checks = 0, errors = 0;
  int rises = 0, rises2 = 0;
  logic prev = 1'b0, prev2 = 1'b0;

  always #2.5 clk = ~clk;
  assign oe_line  = oe_ext  & ~pull;
  assign oe_line2 = oe_ext2 & ~pull2;

  cfg_clk_master #(.DIV_HALF(DIVH), .TOTAL_BITS(NBITS), .DONE_TIMEOUT(TMO),
    .TAIL_CLKS(TAIL), .ERR_PULSE(EPUL), .AUTO_RESTART(1'b0)) u_cfg_clk_master (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe_line), .cs_ni(cs_n), .dclk_o(dclk),
    .oe_pull_o(pull), .master_o(master), .sent_all_o(sent), .idle_o(idle));

  cfg_clk_master #(.DIV_HALF(DIVH), .TOTAL_BITS(NBITS), .DONE_TIMEOUT(TMO),
    .TAIL_CLKS(TAIL), .ERR_PULSE(EPUL), .AUTO_RESTART(1'b1)) u_cfg_clk_master_auto (
    .clk_i(clk), .rst_ni(rst_n), .oe_i(oe_line2), .cs_ni(cs_n2), .dclk_o(dclk2),
    .oe_pull_o(pull2), .master_o(master2), .sent_all_o(sent2), .idle_o(idle2));

  always @(negedge clk) begin
    prev  <= dclk;
    prev2 <= dclk2;
    if (dclk && !prev)   rises  <= rises + 1;
    if (dclk2 && !prev2) rises2 <= rises2 + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic cs_val);
    oe_ext = 1'b0; cs_n = cs_val; cyc(3);
    oe_ext = 1'b1; cyc(2);
  endtask

  task automatic wait_rises(input int base, input int n);
    for (int i = 0; i < 2000 && (rises - base) < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; oe_ext = 1'b0; cs_n = 1'b0; cyc(3);
    rst_n = 1'b1; cyc(2);
  endtask

  initial begin
    int base, hi, lo, n;
    cyc(3);
    // R10 reset state
    chk(!dclk && !pull && !master && !sent && !idle, "R10 reset outputs", {dclk, pull, master, sent, idle}, 0);
    rst_n = 1'b1; cyc(2);

    // R1 follower role
    start(1'b1);
    base = rises; cyc(40);
    chk(master == 1'b0, "R1 follower master_o", master, 0);
    chk(rises - base == 0, "R1 follower no clock", rises - base, 0);

    // R1/R2/R3/R4 normal run, done right at end
    start(1'b0);
    base = rises;
    chk(master == 1'b1, "R1 master role", master, 1);
    for (int i = 0; i < 50 && !dclk; i++) @(negedge clk);
    hi = 0; while (dclk && hi < 50) begin hi++; @(negedge clk); end
    lo = 0; while (!dclk && lo < 50) begin lo++; @(negedge clk); end
    chk(hi == DIVH, "R2 high phase", hi, DIVH);
    chk(lo == DIVH, "R2 low phase", lo, DIVH);
    wait_rises(base, NBITS - 1); @(negedge clk);
    chk(!sent, "R3 sent_all early", sent, 0);
    wait_rises(base, NBITS); @(negedge clk);
    chk(sent, "R3 sent_all at last bit", sent, 1);
    cs_n = 1'b1;
    for (int i = 0; i < 500 && !idle; i++) @(negedge clk);
    cyc(2);
    chk(idle, "R4 idle reached", idle, 1);
    chk(rises - base == NBITS + TAIL, "R4 tail edges", rises - base, NBITS + TAIL);
    cyc(20);
    chk(!dclk && rises - base == NBITS + TAIL, "R4 clock parked", rises - base, NBITS + TAIL);

    // R4 done late but inside timeout
    start(1'b0);
    base = rises;
    wait_rises(base, NBITS + 3); @(negedge clk);
    cs_n = 1'b1;
    for (int i = 0; i < 500 && !idle; i++) @(negedge clk);
    cyc(2);
    chk(idle && !pull, "R4 late done idle", idle, 1);
    chk(rises - base == NBITS + 3 + TAIL, "R4 late tail edges", rises - base, NBITS + 3 + TAIL);

    // R5/R8 early done
    start(1'b0);
    base = rises;
    wait_rises(base, 10);
    cs_n = 1'b1; cyc(3);
    chk(pull, "R5 early done error", pull, 1);
    chk(!sent, "R5 not all sent", sent, 0);
    base = rises;
    oe_ext = 1'b0; cyc(5); oe_ext = 1'b1; cs_n = 1'b0; cyc(30);
    chk(pull, "R8 error sticky", pull, 1);
    chk(rises - base == 0 && !dclk, "R5 clock stopped", rises - base, 0);
    do_reset();
    chk(!pull, "R8 cleared by rst_ni", pull, 0);

    // R6 missing done
    start(1'b0);
    base = rises;
    for (int i = 0; i < 2000 && !pull; i++) @(negedge clk);
    cyc(2);
    chk(pull, "R6 timeout error", pull, 1);
    chk(rises - base == NBITS + TMO, "R6 timeout edge", rises - base, NBITS + TMO);
    do_reset();

    // R7 external reset mid stream
    start(1'b0);
    base = rises;
    wait_rises(base, 12);
    oe_ext = 1'b0; cyc(3);
    base = rises; cyc(10);
    chk(!dclk && rises - base == 0, "R7 clock held low", rises - base, 0);
    chk(!sent && !pull, "R7 cleared", sent, 0);
    oe_ext = 1'b1;
    base = rises;
    wait_rises(base, NBITS - 1); @(negedge clk);
    chk(!sent, "R7 recount early", sent, 0);
    wait_rises(base, NBITS); @(negedge clk);
    chk(sent, "R7 recount full", sent, 1);

    // R9 auto restart
    oe_ext2 = 1'b0; cs_n2 = 1'b0; cyc(3); oe_ext2 = 1'b1; cyc(2);
    base = rises2;
    for (int i = 0; i < 2000 && (rises2 - base) < 5; i++) @(negedge clk);
    cs_n2 = 1'b1;
    for (int i = 0; i < 100 && !pull2; i++) @(negedge clk);
    cs_n2 = 1'b0;
    n = 0; while (pull2 && n < 100) begin n++; @(negedge clk); end
    chk(n == EPUL, "R9 pulse width", n, EPUL);
    cyc(1);
    base = rises2;
    for (int i = 0; i < 2000 && (rises2 - base) < NBITS - 1; i++) @(negedge clk);
    @(negedge clk);
    chk(!sent2 && !pull2, "R9 restart from zero", sent2, 0);
    for (int i = 0; i < 2000 && (rises2 - base) < NBITS; i++) @(negedge clk);
    @(negedge clk);
    chk(sent2, "R9 restart full stream", sent2, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule